// File: doc/BRIEF.md
# CAN Bus Halt and Recovery Controller

This block decides whether a CAN node's protocol engine is running or halted. A halt starts on reset, when the error logic reports entry into bus-off, or when software writes 1 to the halt control bit. How soon a software halt takes effect depends on what the engine is doing. An outgoing frame is allowed to finish, and so is the copy of a received frame into a message buffer. A frame that is only being received is dropped, and the halt starts at once.

While halted, the block keeps the protocol engine and the error counters frozen and forces the transmit line recessive. To leave the halt, software writes 0. The block then watches the sampled receive bit on each bit-time strobe and counts runs of consecutive recessive bits. One run is enough after a reset halt or a software halt. A bus-off halt needs 128 completed runs. On exit the block sends a one-cycle clear to both error counters and reports the node as error active. While the engine runs, the 2-bit node status follows the level reported by the error logic.

Top module: `can_halt_ctrl`

## Requirements
- R1: When reset is released, halt_status, engine_freeze and tx_recessive are 1, node_status is 0 and err_cnt_clear is 0.
- R2: A halt write (cpu_wr=1, cpu_halt_wdata=1) while running, with tx_active=0 and store_active=0, sets halt_status on the next cycle. This holds whether rx_active is 0 or 1.
- R3: A halt write while running with tx_active=1 or store_active=1 leaves halt_status at 0 while either flag stays high. halt_status becomes 1 the cycle after both flags are low.
- R4: A write of 0 made while a halt write is still waiting cancels it, so halt_status stays 0 after the activity ends.
- R5: A bus_off_evt pulse while running sets halt_status and node_status=3 (bus off) on the next cycle, whatever activity is in progress.
- R6: After a reset halt or a software halt, halt_status falls on the clock edge that samples the 11th consecutive recessive bit (bit_strobe=1, rx_bit=1). Only bits sampled after the write of 0 count.
- R7: A dominant bit (rx_bit=0 on a strobe) sets the current run count back to zero but keeps the number of runs already completed.
- R8: After a bus-off halt, the halt ends only when the 128th run of 11 recessive bits completes. Until then node_status stays 3.
- R9: On leaving halt, err_cnt_clear is 1 for exactly one cycle, in the same cycle that halt_status first reads 0, and node_status reads 0 (error active) in that cycle.
- R10: While halted, engine_freeze and tx_recessive are 1 and node_status does not follow err_level_i.
- R11: While running, node_status equals err_level_i as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the node comes out of reset halted |
| cpu_wr | input | 1 | One-cycle strobe: software writes the halt bit |
| cpu_halt_wdata | input | 1 | Halt bit value written: 1 requests a halt, 0 releases it |
| bus_off_evt | input | 1 | Pulse from the error logic when the node enters bus-off |
| err_level_i | input | 2 | Error level from the error logic: 0 active, 1 warning, 2 passive |
| tx_active | input | 1 | A frame is being transmitted |
| rx_active | input | 1 | A frame is being received |
| store_active | input | 1 | A received frame is being written to a buffer |
| rx_bit | input | 1 | Sampled receive bit, 1 is recessive |
| bit_strobe | input | 1 | One-cycle pulse marking the sample point of each bit |
| halt_status | output | 1 | 1 while halted, 0 while the bus is operating |
| engine_freeze | output | 1 | Stops the protocol engine and the error counters from updating |
| tx_recessive | output | 1 | Forces the transmit output recessive |
| err_cnt_clear | output | 1 | One-cycle clear of both error counters on leaving halt |
| node_status | output | 2 | 0 error active, 1 warning, 2 error passive, 3 bus off |

## Verification
The bench sweeps every combination of the three activity flags at the moment of a halt write. A design that mixed up which activity is waited for would either cut off a transmission or the copy into a buffer, or would keep receiving after being told to stop. Recovery is checked one bit short of the limit and on the limit. It is also checked with strobes sent before the release write, and with a dominant bit in the middle of a run. An off-by-one counter, a design that counts before software releases the halt, or one that clears the completed-run count on a dominant bit would all end the halt in the wrong cycle. The full bus-off recovery checks the 128-run limit, the held bus-off status, and the one-cycle counter clear that comes with status 0.

// File: rtl/cbh_pkg.sv
package cbh_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PEND  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_COUNT = 2'd3
    } cbh_state_e;

    typedef enum logic [1:0] {
        NS_ACTIVE  = 2'd0,
        NS_WARN    = 2'd1,
        NS_PASSIVE = 2'd2,
        NS_BUSOFF  = 2'd3
    } node_stat_e;

    typedef enum logic [1:0] {
        ENT_IDLE       = 2'd0,
        ENT_RX_ABORT   = 2'd1,
        ENT_WAIT_STORE = 2'd2,
        ENT_WAIT_TX    = 2'd3
    } entry_cls_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic store;
    } activity_t;

    typedef struct packed {
        logic wr;
        logic val;
    } cpu_req_t;

    function automatic entry_cls_e classify(activity_t a);
        if (a.tx)          return ENT_WAIT_TX;
        else if (a.store)  return ENT_WAIT_STORE;
        else if (a.rx)     return ENT_RX_ABORT;
        else               return ENT_IDLE;
    endfunction

    function automatic logic must_wait(entry_cls_e c);
        return (c == ENT_WAIT_TX) || (c == ENT_WAIT_STORE);
    endfunction

    function automatic logic is_halted(cbh_state_e s);
        return (s == ST_HOLD) || (s == ST_COUNT);
    endfunction

endpackage

// File: rtl/cbh_run_counter.sv
module cbh_run_counter
    import cbh_pkg::*;
#(
    parameter int RUN_LEN     = 11,
    parameter int BUSOFF_RUNS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic count_en,
    input  logic strobe,
    input  logic rx,
    input  logic busoff_mode,
    output logic seq_done
);
    localparam int RUN_W  = $clog2(RUN_LEN + 1);
    localparam int RUNS_W = $clog2(BUSOFF_RUNS + 1);
    localparam logic [RUN_W-1:0]  LAST_BIT    = RUN_W'(RUN_LEN - 1);
    localparam logic [RUNS_W-1:0] LAST_RUN_BO = RUNS_W'(BUSOFF_RUNS - 1);

    logic [RUN_W-1:0]  bit_q;
    logic [RUNS_W-1:0] runs_q;
    logic              last_bit;
    logic              last_run;
    logic              sample;

    assign sample   = count_en && strobe;
    assign last_bit = (bit_q == LAST_BIT);
    assign last_run = busoff_mode ? (runs_q == LAST_RUN_BO) : (runs_q == '0);
    assign seq_done = sample && rx && last_bit && last_run;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bit_q  <= '0;
            runs_q <= '0;
        end else if (sample) begin
            if (!rx) begin
                bit_q <= '0;
            end else if (last_bit) begin
                bit_q  <= '0;
                runs_q <= runs_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cbh_mode_fsm.sv
module cbh_mode_fsm
    import cbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cpu_req_t   cpu_req,
    input  logic       bus_off_evt,
    input  activity_t  act,
    input  logic       seq_done,
    output cbh_state_e state,
    output logic       busoff_mode,
    output logic       restart,
    output logic       enter_busoff,
    output logic       leave_halt,
    output logic       clr_pulse
);
    cbh_state_e state_q, state_n;
    logic       bo_q, bo_n;
    logic       clr_q;
    logic       wr_one, wr_zero, hold_off;

    assign wr_one   = cpu_req.wr && cpu_req.val;
    assign wr_zero  = cpu_req.wr && !cpu_req.val;
    assign hold_off = must_wait(classify(act));

    always_comb begin
        state_n      = state_q;
        bo_n         = bo_q;
        restart      = 1'b0;
        enter_busoff = 1'b0;
        leave_halt   = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (bus_off_evt) begin
                    state_n      = ST_HOLD;
                    bo_n         = 1'b1;
                    enter_busoff = 1'b1;
                end else if (wr_one) begin
                    state_n = hold_off ? ST_PEND : ST_HOLD;
                end
            end
            ST_PEND: begin
                if (bus_off_evt) begin
                    state_n      = ST_HOLD;
                    bo_n         = 1'b1;
                    enter_busoff = 1'b1;
                end else if (wr_zero) begin
                    state_n = ST_RUN;
                end else if (!hold_off) begin
                    state_n = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (wr_zero) begin
                    state_n = ST_COUNT;
                    restart = 1'b1;
                end
            end
            ST_COUNT: begin
                if (wr_one) begin
                    state_n = ST_HOLD;
                    restart = 1'b1;
                end else if (seq_done) begin
                    state_n    = ST_RUN;
                    bo_n       = 1'b0;
                    leave_halt = 1'b1;
                end
            end
            default: state_n = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            bo_q    <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            bo_q    <= bo_n;
            clr_q   <= leave_halt;
        end
    end

    assign state       = state_q;
    assign busoff_mode = bo_q;
    assign clr_pulse   = clr_q;

endmodule

// File: rtl/cbh_status_reg.sv
module cbh_status_reg
    import cbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       running,
    input  logic       enter_busoff,
    input  logic       leave_halt,
    input  logic [1:0] err_level,
    output logic [1:0] status
);
    node_stat_e stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= NS_ACTIVE;
        end else if (enter_busoff) begin
            stat_q <= NS_BUSOFF;
        end else if (leave_halt) begin
            stat_q <= NS_ACTIVE;
        end else if (running) begin
            stat_q <= node_stat_e'(err_level);
        end
    end

    assign status = stat_q;

endmodule

// File: rtl/can_halt_ctrl.sv
module can_halt_ctrl
    import cbh_pkg::*;
#(
    parameter int RUN_LEN     = 11,
    parameter int BUSOFF_RUNS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_wr,
    input  logic       cpu_halt_wdata,
    input  logic       bus_off_evt,
    input  logic [1:0] err_level_i,
    input  logic       tx_active,
    input  logic       rx_active,
    input  logic       store_active,
    input  logic       rx_bit,
    input  logic       bit_strobe,
    output logic       halt_status,
    output logic       engine_freeze,
    output logic       tx_recessive,
    output logic       err_cnt_clear,
    output logic [1:0] node_status
);
    cpu_req_t   req;
    activity_t  act;
    cbh_state_e state;
    logic       busoff_mode, restart, enter_busoff, leave_halt, seq_done;
    logic       halted;

    assign req = '{wr: cpu_wr, val: cpu_halt_wdata};
    assign act = '{tx: tx_active, rx: rx_active, store: store_active};

    cbh_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (req),
        .bus_off_evt  (bus_off_evt),
        .act          (act),
        .seq_done     (seq_done),
        .state        (state),
        .busoff_mode  (busoff_mode),
        .restart      (restart),
        .enter_busoff (enter_busoff),
        .leave_halt   (leave_halt),
        .clr_pulse    (err_cnt_clear)
    );

    cbh_run_counter #(
        .RUN_LEN     (RUN_LEN),
        .BUSOFF_RUNS (BUSOFF_RUNS)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .count_en    (state == ST_COUNT),
        .strobe      (bit_strobe),
        .rx          (rx_bit),
        .busoff_mode (busoff_mode),
        .seq_done    (seq_done)
    );

    cbh_status_reg u_stat (
        .clk          (clk),
        .rst          (rst),
        .running      (!halted),
        .enter_busoff (enter_busoff),
        .leave_halt   (leave_halt),
        .err_level    (err_level_i),
        .status       (node_status)
    );

    assign halted        = is_halted(state);
    assign halt_status   = halted;
    assign engine_freeze = halted;
    assign tx_recessive  = halted;

endmodule

// File: rtl/cbh_halt_chk.sv
module cbh_halt_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic       cpu_halt_wdata,
    input logic       bus_off_evt,
    input logic       tx_active,
    input logic       store_active,
    input logic       rx_bit,
    input logic       bit_strobe,
    input logic       halt_status,
    input logic       err_cnt_clear,
    input logic [1:0] node_status
);
    p_now_halt_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_halt_wdata && !halt_status && !tx_active && !store_active)
        |=> halt_status);

    p_wait_activity_r3: assert property (@(posedge clk) disable iff (rst)
        (!halt_status && (tx_active || store_active) && !bus_off_evt)
        |=> !halt_status);

    p_busoff_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_off_evt && !halt_status) |=> (halt_status && node_status == 2'd3));

    p_exit_on_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_status) |-> ($past(bit_strobe) && $past(rx_bit)));

    p_clear_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_status) |-> (err_cnt_clear && node_status == 2'd0));

    p_clear_single_r9: assert property (@(posedge clk) disable iff (rst)
        err_cnt_clear |=> !err_cnt_clear);

    p_status_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (halt_status && $past(halt_status)) |-> $stable(node_status));

endmodule

bind can_halt_ctrl cbh_halt_chk u_chk (.*);

// File: tb/sim_can_halt_ctrl.sv
module sim_can_halt_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0, cpu_halt_wdata = 1'b0, bus_off_evt = 1'b0;
    logic [1:0] err_level_i = 2'd0;
    logic       tx_active = 1'b0, rx_active = 1'b0, store_active = 1'b0;
    logic       rx_bit = 1'b1, bit_strobe = 1'b0;
    logic       halt_status, engine_freeze, tx_recessive, err_cnt_clear;
    logic [1:0] node_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    can_halt_ctrl u0 (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_halt_wdata(cpu_halt_wdata),
        .bus_off_evt(bus_off_evt), .err_level_i(err_level_i),
        .tx_active(tx_active), .rx_active(rx_active), .store_active(store_active),
        .rx_bit(rx_bit), .bit_strobe(bit_strobe),
        .halt_status(halt_status), .engine_freeze(engine_freeze),
        .tx_recessive(tx_recessive), .err_cnt_clear(err_cnt_clear),
        .node_status(node_status)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic v);
        cpu_wr = 1'b1;
        cpu_halt_wdata = v;
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        bit_strobe = 1'b1;
        rx_bit = v;
        step();
        bit_strobe = 1'b0;
        rx_bit = 1'b1;
    endtask

    task automatic send_run(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic recover_normal(input string req);
        cpu_write(1'b0);
        send_run(10);
        check({req, " halted one bit short"}, halt_status, 1);
        send_bit(1'b1);
        check({req, " running after 11th bit"}, halt_status, 0);
        check("R9 clear pulse at exit", err_cnt_clear, 1);
        check("R9 status active at exit", node_status, 0);
        step();
        check("R9 clear lasts one cycle", err_cnt_clear, 0);
    endtask

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        check("R1 halted after reset", halt_status, 1);
        check("R1 freeze after reset", engine_freeze, 1);
        check("R1 tx recessive after reset", tx_recessive, 1);
        check("R1 status after reset", node_status, 0);
        check("R1 no clear after reset", err_cnt_clear, 0);

        // R6: bits before the release write do not count
        send_run(11);
        check("R6 no count before write 0", halt_status, 1);

        // R7: a dominant bit restarts the current run
        cpu_write(1'b0);
        send_run(6);
        send_bit(1'b0);
        send_run(10);
        check("R7 halted after dominant restart", halt_status, 1);
        send_bit(1'b1);
        check("R7 running after full run", halt_status, 0);
        check("R9 clear after R7 recovery", err_cnt_clear, 1);
        step();

        // R11: status follows error level while running
        for (int lv = 2; lv >= 0; lv--) begin
            err_level_i = 2'(lv);
            step();
            check("R11 status follows level", node_status, lv);
        end

        // R2/R3: sweep every activity combination at the halt write
        for (int c = 0; c < 8; c++) begin
            int waits;
            tx_active    = c[2];
            rx_active    = c[1];
            store_active = c[0];
            waits = (c[2] || c[0]) ? 1 : 0;
            cpu_write(1'b1);
            check(waits ? "R3 halt deferred" : "R2 halt immediate", halt_status, 1 - waits);
            for (int k = 0; k < 3; k++) begin
                step();
                check(waits ? "R3 still deferred" : "R2 stays halted", halt_status, 1 - waits);
            end
            tx_active = 1'b0;
            rx_active = 1'b0;
            store_active = 1'b0;
            step();
            check("R3 halted after activity ends", halt_status, 1);
            check("R10 freeze while halted", engine_freeze, 1);
            check("R10 tx recessive while halted", tx_recessive, 1);
            err_level_i = 2'd1;
            step();
            check("R10 status held while halted", node_status, 0);
            err_level_i = 2'd0;
            recover_normal("R6");
        end

        // R4: a write of 0 cancels a waiting halt
        tx_active = 1'b1;
        cpu_write(1'b1);
        cpu_write(1'b0);
        tx_active = 1'b0;
        step();
        step();
        check("R4 pending halt cancelled", halt_status, 0);

        // R5/R8: bus-off halt and the long recovery
        err_level_i = 2'd2;
        step();
        tx_active = 1'b1;
        bus_off_evt = 1'b1;
        step();
        bus_off_evt = 1'b0;
        tx_active = 1'b0;
        check("R5 halted on bus-off", halt_status, 1);
        check("R5 status bus off", node_status, 3);
        send_run(11);
        cpu_write(1'b0);
        for (int r = 0; r < 40; r++) send_run(11);
        send_run(6);
        send_bit(1'b0);
        for (int r = 0; r < 87; r++) send_run(11);
        check("R8 halted after 127 runs", halt_status, 1);
        check("R8 status stays bus off", node_status, 3);
        check("R10 status ignores level in bus-off", node_status, 3);
        err_level_i = 2'd0;
        send_run(10);
        check("R8 halted one bit short", halt_status, 1);
        send_bit(1'b1);
        check("R8 running after 128th run", halt_status, 0);
        check("R9 clear after bus-off exit", err_cnt_clear, 1);
        check("R9 status active after bus-off", node_status, 0);
        step();
        check("R9 clear single after bus-off", err_cnt_clear, 0);
        check("R9 status still active", node_status, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule